// File: doc/BRIEF.md
# Scaled-Index Effective Address Decoder

This block turns the addressing bytes that follow an opcode into a 32-bit memory offset. It is meant for a 32-bit register machine with eight general registers. It receives a window of operand bytes from the instruction stream. Byte 0 of the window is always the addressing-mode byte. An optional second addressing byte, called the index byte here, may follow it. Any displacement comes after the addressing bytes. The block works out which of these bytes are present. It drives the two register-file read addresses it needs and takes back the two read values in the same cycle. From these it forms base + index × scale + displacement.

Next to the offset, the block reports four things: whether the default segment is the stack segment, how many addressing bytes the operand used (not counting the opcode), whether the extra indexed-address cycle applies, and whether the mode byte named a register rather than memory. Two registers need special handling. Register 4, the stack pointer, may appear only in the base position, and using it as a base always costs an index byte. Register 5, the frame pointer, always carries a displacement and selects the stack segment. Results leave through one output register stage, or through none when the parameter `REG_OUT` is 0.

Top module: `ea_offset_decoder`

## Requirements
- R1: When the operand is in memory, the offset is (base value + scaled index value + displacement) modulo 2^XLEN. A missing base or a missing index contributes 0.
- R2: The index byte's field [7:6] selects the index scale. The codes 0, 1, 2 and 3 multiply the index register value by 1, 2, 4 and 8.
- R3: An index field [5:3] equal to 4 means no index term. Register 4 is therefore never used as an index, and only the base fields can select it.
- R4: The base field [2:0] and the index field [5:3] of the index byte may name the same register (other than 4). That register's value then counts once as base and once, scaled, as index.
- R5: Mode field [7:6] = 01 takes one displacement byte and sign-extends it (range -128..+127). Mode field = 10 takes four bytes, least significant byte first. Mode field = 00 normally takes none, and no two-byte form exists. Window bytes beyond the consumed length have no effect on any output.
- R6: out_penalty is 1 exactly when an index byte is present and its index field is not 4.
- R7: Mode-byte field [2:0] = 4 with mode field ≠ 11 means an index byte follows at byte 1. With index field 4, this gives a stack-pointer base of length 2 or more, and out_penalty stays 0.
- R8: out_stack_seg is 1 when the base register is 4 or 5. It is 0 when the base is another register, when there is no base, and for register-direct operands.
- R9: Mode field 00 with mode-byte field [2:0] = 5 means no base and a 4-byte absolute displacement at byte 1. Mode field 00 with index-byte base field = 5 means no base and a 4-byte displacement at byte 2. Register 5 as a base therefore always has at least a 1-byte displacement.
- R10: out_len = 1 + (1 if an index byte is present) + displacement size. So register-indirect gives 1, with an 8-bit displacement 2, with a 32-bit displacement 5, and 4 never occurs.
- R11: Mode field 11 sets out_reg_direct. It also forces out_len = 1, out_penalty = 0, out_stack_seg = 0 and out_offset = 0.
- R12: With REG_OUT = 1, every result appears one clock after its input. out_valid follows in_valid with one cycle of delay, and reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand window is valid this cycle |
| opnd_bytes | input | 8*WIN (48) | Operand window; byte k is at bits [8k+7:8k] |
| rf_addr_base | output | 3 | Register-file read address for the base |
| rf_addr_index | output | 3 | Register-file read address for the index |
| rf_data_base | input | XLEN (32) | Read data for rf_addr_base, same cycle |
| rf_data_index | input | XLEN (32) | Read data for rf_addr_index, same cycle |
| out_valid | output | 1 | Result valid |
| out_offset | output | XLEN (32) | Effective offset |
| out_stack_seg | output | 1 | Default segment is the stack segment |
| out_len | output | 3 | Addressing bytes consumed |
| out_penalty | output | 1 | Indexed addressing costs an extra cycle |
| out_reg_direct | output | 1 | Operand is a register, not memory |

## Verification
The hardest cases to reach are the ones where the index byte itself changes the layout. These are an index field of 4 combined with a stack-pointer base, and a base field of 5 under mode 00, which moves the displacement and removes the base. The bench reaches them by sweeping every mode byte and, wherever an index byte follows, every one of its 256 values. All of this runs under two register-file images, one of which makes the sums wrap past 2^32. Every window byte that is not an addressing byte is filled from a pseudo-random sequence. As a result, stray displacement bytes and bytes past the consumed length change from vector to vector, and any use of the wrong bytes shows up in the offset.

// File: rtl/ea_pkg.sv
`timescale 1ns/1ps
package ea_pkg;
   localparam logic [2:0] REG_SP = 3'd4;
   localparam logic [2:0] REG_FP = 3'd5;

   typedef enum logic [1:0] {
      MD_NODISP = 2'b00,
      MD_D8     = 2'b01,
      MD_D32    = 2'b10,
      MD_REG    = 2'b11
   } md_e;

   typedef enum logic [1:0] {
      DS_NONE = 2'd0,
      DS_BYTE = 2'd1,
      DS_WORD = 2'd2
   } dsz_e;

   typedef struct packed {
      logic       reg_direct;
      logic       has_ixb;
      logic       base_en;
      logic [2:0] base_sel;
      logic       index_en;
      logic [2:0] index_sel;
      logic [1:0] scale;
      dsz_e       dsz;
      logic       stack_seg;
      logic [2:0] len;
      logic       penalty;
   } ctl_t;

   function automatic logic [2:0] dsz_bytes(dsz_e d);
      case (d)
         DS_BYTE: return 3'd1;
         DS_WORD: return 3'd4;
         default: return 3'd0;
      endcase
   endfunction
endpackage

// File: rtl/ea_mode_decode.sv
`timescale 1ns/1ps
module ea_mode_decode
   import ea_pkg::*;
(
   input  logic [7:0] mode_b,
   input  logic [7:0] ix_b,
   output ctl_t       ctl
);
   md_e        md;
   logic [2:0] rm;
   logic [2:0] bsel;
   logic       nobase;

   always_comb begin
      md     = md_e'(mode_b[7:6]);
      rm     = mode_b[2:0];
      ctl    = '0;
      bsel   = 3'd0;
      nobase = 1'b0;
      if (md == MD_REG) begin
         ctl.reg_direct = 1'b1;
         ctl.len        = 3'd1;
      end else begin
         ctl.has_ixb = (rm == REG_SP);
         case (md)
            MD_D8:   ctl.dsz = DS_BYTE;
            MD_D32:  ctl.dsz = DS_WORD;
            default: ctl.dsz = DS_NONE;
         endcase
         if (ctl.has_ixb) begin
            ctl.scale     = ix_b[7:6];
            ctl.index_sel = ix_b[5:3];
            ctl.index_en  = (ix_b[5:3] != REG_SP);
            bsel          = ix_b[2:0];
         end else begin
            bsel = rm;
         end
         // frame pointer under mode 00 becomes an absolute displacement
         nobase = (md == MD_NODISP) && (bsel == REG_FP);
         if (nobase) begin
            ctl.dsz     = DS_WORD;
            ctl.base_en = 1'b0;
         end else begin
            ctl.base_en  = 1'b1;
            ctl.base_sel = bsel;
         end
         ctl.stack_seg = ctl.base_en && (bsel == REG_SP || bsel == REG_FP);
         ctl.penalty   = ctl.index_en;
         ctl.len       = 3'd1 + {2'b00, ctl.has_ixb} + dsz_bytes(ctl.dsz);
      end
   end
endmodule

// File: rtl/ea_disp_fetch.sv
`timescale 1ns/1ps
module ea_disp_fetch
   import ea_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int WIN  = 6
)(
   input  logic [8*WIN-1:0] win,
   input  logic             after_ixb,
   input  dsz_e             dsz,
   output logic [XLEN-1:0]  disp
);
   logic [7:0]  b8;
   logic [31:0] w32;

   always_comb begin
      b8  = after_ixb ? win[23:16] : win[15:8];
      w32 = after_ixb ? win[47:16] : win[39:8];
   end

   generate
      if (XLEN == 32) begin : g_narrow
         always_comb begin
            case (dsz)
               DS_BYTE: disp = {{24{b8[7]}}, b8};
               DS_WORD: disp = w32;
               default: disp = '0;
            endcase
         end
      end else begin : g_wide
         always_comb begin
            case (dsz)
               DS_BYTE: disp = {{(XLEN-8){b8[7]}}, b8};
               DS_WORD: disp = {{(XLEN-32){w32[31]}}, w32};
               default: disp = '0;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/ea_agu.sv
`timescale 1ns/1ps
module ea_agu #(
   parameter int XLEN = 32
)(
   input  logic            base_en,
   input  logic [XLEN-1:0] base_val,
   input  logic            index_en,
   input  logic [XLEN-1:0] index_val,
   input  logic [1:0]      scale,
   input  logic [XLEN-1:0] disp,
   output logic [XLEN-1:0] offset
);
   logic [XLEN-1:0] b_term;
   logic [XLEN-1:0] x_term;

   always_comb begin
      b_term = base_en  ? base_val : '0;
      x_term = index_en ? (index_val << scale) : '0;
      offset = b_term + x_term + disp;
   end
endmodule

// File: rtl/ea_offset_decoder.sv
`timescale 1ns/1ps
module ea_offset_decoder
   import ea_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int WIN     = 6,
   parameter bit REG_OUT = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [8*WIN-1:0]  opnd_bytes,
   output logic [2:0]        rf_addr_base,
   output logic [2:0]        rf_addr_index,
   input  logic [XLEN-1:0]   rf_data_base,
   input  logic [XLEN-1:0]   rf_data_index,
   output logic              out_valid,
   output logic [XLEN-1:0]   out_offset,
   output logic              out_stack_seg,
   output logic [2:0]        out_len,
   output logic              out_penalty,
   output logic              out_reg_direct
);
   localparam bit CFG_OK = (XLEN >= 32) && (WIN >= 6);

   initial begin
      if (!CFG_OK) $fatal(1, "ea_offset_decoder: XLEN must be >= 32 and WIN >= 6");
   end

   ctl_t            ctl;
   logic [XLEN-1:0] disp;
   logic [XLEN-1:0] off_c;

   ea_mode_decode u_dec (
      .mode_b (opnd_bytes[7:0]),
      .ix_b   (opnd_bytes[15:8]),
      .ctl    (ctl)
   );

   ea_disp_fetch #(.XLEN(XLEN), .WIN(WIN)) u_disp (
      .win       (opnd_bytes),
      .after_ixb (ctl.has_ixb),
      .dsz       (ctl.dsz),
      .disp      (disp)
   );

   assign rf_addr_base  = ctl.base_sel;
   assign rf_addr_index = ctl.index_sel;

   ea_agu #(.XLEN(XLEN)) u_agu (
      .base_en   (ctl.base_en),
      .base_val  (rf_data_base),
      .index_en  (ctl.index_en),
      .index_val (rf_data_index),
      .scale     (ctl.scale),
      .disp      (disp),
      .offset    (off_c)
   );

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid      <= 1'b0;
               out_offset     <= '0;
               out_stack_seg  <= 1'b0;
               out_len        <= 3'd0;
               out_penalty    <= 1'b0;
               out_reg_direct <= 1'b0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  out_offset     <= off_c;
                  out_stack_seg  <= ctl.stack_seg;
                  out_len        <= ctl.len;
                  out_penalty    <= ctl.penalty;
                  out_reg_direct <= ctl.reg_direct;
               end
            end
         end

         // R12
         valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         // R12
         valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
         // R11
         reg_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_reg_direct) |->
            (out_len == 3'd1 && !out_penalty && !out_stack_seg && out_offset == '0));
         // R6
         no_ixb_no_penalty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && opnd_bytes[2:0] != 3'd4) |=> !out_penalty);
         // R7
         sp_base_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && opnd_bytes[2:0] == 3'd4 && opnd_bytes[7:6] != 2'b11) |=>
            (out_len >= 3'd2));
         // R10
         len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_len == 3'd1 || out_len == 3'd2 || out_len == 3'd3 ||
                           out_len == 3'd5 || out_len == 3'd6));
         // R8
         stack_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_stack_seg) |-> !out_reg_direct);
         // R9
         absolute_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && opnd_bytes[7:6] == 2'b00 && opnd_bytes[2:0] == 3'd5) |=>
            (out_len == 3'd5 && !out_stack_seg && !out_penalty &&
             out_offset[31:0] == $past(opnd_bytes[39:8])));
      end else begin : g_comb
         always_comb begin
            out_valid      = in_valid;
            out_offset     = off_c;
            out_stack_seg  = ctl.stack_seg;
            out_len        = ctl.len;
            out_penalty    = ctl.penalty;
            out_reg_direct = ctl.reg_direct;
         end
      end
   endgenerate
endmodule

// File: tb/tb_ea_offset_decoder.sv
`timescale 1ns/1ps
module tb_ea_offset_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [47:0] opnd_bytes = '0;
   logic [2:0]  rf_addr_base, rf_addr_index;
   logic [31:0] rf_data_base, rf_data_index;
   logic        out_valid, out_stack_seg, out_penalty, out_reg_direct;
   logic [31:0] out_offset;
   logic [2:0]  out_len;

   logic [31:0] rf [8];
   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [31:0] lcg = 32'h1234_5678;

   always #5 clk = ~clk;

   assign rf_data_base  = rf[rf_addr_base];
   assign rf_data_index = rf[rf_addr_index];

   ea_offset_decoder dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd_bytes(opnd_bytes),
      .rf_addr_base(rf_addr_base), .rf_addr_index(rf_addr_index),
      .rf_data_base(rf_data_base), .rf_data_index(rf_data_index),
      .out_valid(out_valid), .out_offset(out_offset), .out_stack_seg(out_stack_seg),
      .out_len(out_len), .out_penalty(out_penalty), .out_reg_direct(out_reg_direct)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h (window %h)", req, what, act, exp, opnd_bytes);
      end
   endtask

   // Expected result from the requirement text (R1..R11)
   task automatic model(input logic [47:0] w, output logic [31:0] e_off, output logic [2:0] e_len,
                        output logic e_stk, output logic e_pen, output logic e_rd);
      logic [1:0] md;
      logic [2:0] rmf, bs, xi;
      logic hb, nob;
      int pos, dlen;
      logic [31:0] d, bv, xv;
      md = w[7:6]; rmf = w[2:0];
      e_off = 0; e_len = 1; e_stk = 0; e_pen = 0; e_rd = 0;
      if (md == 2'b11) begin
         e_rd = 1;                                   // R11
      end else begin
         hb = (rmf == 3'd4);                         // R7
         pos = hb ? 2 : 1;
         bs = hb ? w[10:8] : rmf;
         xi = w[13:11];
         nob = (md == 2'b00) && (bs == 3'd5);        // R9
         dlen = (md == 2'b01) ? 1 : (md == 2'b10) ? 4 : (nob ? 4 : 0);   // R5
         d = 0;
         if (dlen == 1) d = {{24{w[8*pos+7]}}, w[8*pos +: 8]};
         if (dlen == 4) d = w[8*pos +: 32];
         bv = nob ? 32'd0 : rf[bs];
         xv = (hb && xi != 3'd4) ? rf[xi] * (32'd1 << w[15:14]) : 32'd0;  // R2 R3 R4
         e_off = bv + xv + d;                         // R1
         e_len = 3'(pos + dlen);                      // R10
         e_stk = !nob && (bs == 3'd4 || bs == 3'd5); // R8
         e_pen = hb && (xi != 3'd4);                 // R6
      end
   endtask

   task automatic apply(input logic [47:0] w, input string req);
      logic [31:0] e_off; logic [2:0] e_len; logic e_stk, e_pen, e_rd;
      @(negedge clk);
      opnd_bytes = w;
      in_valid = 1'b1;
      model(w, e_off, e_len, e_stk, e_pen, e_rd);
      @(posedge clk);
      #1;
      chk("R12", "out_valid", {31'd0, out_valid}, 32'd1);
      chk(req, "offset", out_offset, e_off);
      chk("R10", "len", {29'd0, out_len}, {29'd0, e_len});
      chk("R8", "stack_seg", {31'd0, out_stack_seg}, {31'd0, e_stk});
      chk("R6", "penalty", {31'd0, out_penalty}, {31'd0, e_pen});
      chk("R11", "reg_direct", {31'd0, out_reg_direct}, {31'd0, e_rd});
   endtask

   function automatic logic [47:0] noise();
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      return {lcg[15:0], lcg ^ 32'h9E37_79B9};
   endfunction

   initial begin
      logic [47:0] w;
      for (int i = 0; i < 8; i++) rf[i] = 32'h0101_0101 * (i + 1);
      repeat (3) @(posedge clk);
      #1;
      // R12 reset state
      chk("R12", "reset out_valid", {31'd0, out_valid}, 32'd0);
      chk("R12", "reset offset", out_offset, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // Directed corner cases
      apply({40'h0, 8'h03}, "R10");                      // [reg3], len 1
      apply({32'h0, 8'h80, 8'h43}, "R5");                // disp8 -128
      apply({8'h0, 32'h0001_0000, 8'h83}, "R10");        // disp32, len 5
      apply({8'h0, 32'hDEAD_BEEF, 8'h05}, "R9");         // absolute
      apply({32'h0, 8'hE4, 8'h04}, "R7");                // sp base, no index
      apply({32'h0, 8'hDB, 8'h04}, "R4");                // base=index=3, scale 8
      apply({32'h0, 8'hC8, 8'h04}, "R2");                // index1*8 + base0
      apply({32'h0, 8'h25, 8'h04}, "R3");                // index 4 => none, base 5 mod00 => abs
      apply({40'h0, 8'hC1}, "R11");                      // register-direct
      // R12: in_valid low gives out_valid low next cycle
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk);
      #1;
      chk("R12", "idle out_valid", {31'd0, out_valid}, 32'd0);

      // Sweeps: all mode bytes, all index bytes, two register images (second wraps)
      for (int p = 0; p < 2; p++) begin
         for (int i = 0; i < 8; i++)
            rf[i] = (p == 0) ? 32'h0001_0000 * (i + 1) + i : 32'hF000_0000 + 32'h0F11_1111 * i;
         for (int m = 0; m < 256; m++) begin
            if (m[2:0] == 3'd4 && m[7:6] != 2'b11) begin
               for (int x = 0; x < 256; x++) begin
                  w = noise();
                  w[7:0] = 8'(m);
                  w[15:8] = 8'(x);
                  apply(w, "R1");
               end
            end else begin
               w = noise();
               w[7:0] = 8'(m);
               apply(w, "R1");
            end
         end
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule